// File: doc/BRIEF.md
# Branch Resolution Unit

This block settles every control-flow operation of the core. Operations come in over a valid/ready stream into a two-entry in-order station. The unit resolves the oldest entry: it evaluates the 4-bit condition code against the speculative flag operand, or compares the actual call/return target with the predicted one. It then reports the real next address, whether the front end guessed wrong, and the 0/1 byte that a conditional set produces. It is the only place in the core where condition codes are decoded.

The result leaves on a second valid/ready stream that is held in one output register. When the station is empty and the output register is free, an arriving operation bypasses the station and its result is visible one clock after the handshake. A correctly predicted branch therefore costs no extra cycle. Back-pressure works as follows. The consumer may hold `res_ready` low for any length of time, and the result stays frozen until it is taken. The producer may present `in_valid` at any time, and an operation is accepted only in a cycle where `in_ready` is high. When a resolved operation mispredicts, every younger operation is discarded. This includes entries waiting in the station and an input accepted in that same cycle.

Top module: `branch_resolve_unit`

## Requirements
- R1: The condition field uses bits [3:1] to select a test and bit 0 to invert it. The tests, by value of [3:1], are: 0 overflow, 1 carry, 2 zero, 3 carry-or-zero, 4 sign, 5 parity, 6 sign≠overflow, 7 zero-or-(sign≠overflow). The flag operand packs carry at bit 0, parity at bit 1, zero at bit 2, sign at bit 3 and overflow at bit 4.
- R2: For a conditional jump (op 0), the actual direction is the condition result. The reported target is the taken target if the branch is taken and the fall-through target otherwise. A mispredict is raised exactly when the actual direction differs from the predicted direction.
- R3: For a conditional byte-set (op 1), the result byte is 8'h01 when the condition holds and 8'h00 when it does not. No mispredict is raised, and the target is the fall-through address. Every other operation yields a byte of 8'h00.
- R4: For a call (op 2) or a return (op 3), the target is the actual target operand. A mispredict is raised exactly when the predicted target differs from it.
- R5: A microbranch (op 5) resolves under the same direction and target rules as a conditional jump.
- R6: A floating-point exchange (op 4) and the unused codes 6 and 7 never mispredict, and they report the fall-through address.
- R7: Zero added delay applies under two conditions: the station is empty and the output register is empty or being drained. Under those conditions, an accepted operation's result is valid on the clock after acceptance.
- R8: The station holds two operations and resolves them in acceptance order. `in_ready` is low while both entries are occupied.
- R9: A mispredicting resolution discards all younger operations, including one accepted in the same cycle. No result ever appears for them.
- R10: While `res_valid` is high and `res_ready` is low, every result field holds its value.
- R11: After reset, `res_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Station can accept |
| in_op | input | 3 | Operation type (0 jump, 1 byte-set, 2 call, 3 return, 4 exchange, 5 microbranch) |
| in_cond | input | 4 | Condition code |
| in_flags | input | 5 | Speculative flag operand |
| in_pred_taken | input | 1 | Predicted direction |
| in_pred_target | input | 32 | Predicted next address |
| in_fall_target | input | 32 | Sequential next address |
| in_taken_target | input | 32 | Branch or actual call/return target |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes result |
| res_op | output | 3 | Operation type of the result |
| res_mispredict | output | 1 | Front end must redirect |
| res_target | output | 32 | Actual next address |
| res_setbyte | output | 8 | Byte-set result |

## Verification
Suppose the condition decoder or an operation's rule goes wrong. The next result for that operation then carries a wrong mispredict bit, target or byte, visible one clock after it issues. A corrupted station count or ordering shows up in two ways. One is an `in_ready` that stays high with two entries waiting. The other is a result that arrives out of order, or appears after a mispredict should have flushed it, within two or three cycles of the stall being released. A faulty output hold makes fields change while `res_ready` is low, in the very next cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned BRU_AW = 32;
  localparam int unsigned BRU_FW = 5;

  typedef enum logic [2:0] {
    OP_JCC   = 3'd0,
    OP_SETCC = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_FXCH  = 3'd4,
    OP_UBR   = 3'd5
  } bru_op_e;

  typedef struct packed {
    logic [2:0]        op;
    logic [3:0]        cc;
    logic [BRU_FW-1:0] flags;
    logic              pred_taken;
    logic [BRU_AW-1:0] pred_target;
    logic [BRU_AW-1:0] fall_target;
    logic [BRU_AW-1:0] taken_target;
  } bru_entry_t;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
(
  input  logic [3:0]        cc,
  input  logic [BRU_FW-1:0] flags,
  output logic              holds
);
  logic f_cf, f_pf, f_zf, f_sf, f_of, base;

  assign f_cf = flags[0];
  assign f_pf = flags[1];
  assign f_zf = flags[2];
  assign f_sf = flags[3];
  assign f_of = flags[4];

  always_comb begin
    unique case (cc[3:1])
      3'd0: base = f_of;
      3'd1: base = f_cf;
      3'd2: base = f_zf;
      3'd3: base = f_cf | f_zf;
      3'd4: base = f_sf;
      3'd5: base = f_pf;
      3'd6: base = f_sf ^ f_of;
      default: base = f_zf | (f_sf ^ f_of);
    endcase
  end

  assign holds = base ^ cc[0];
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
  import bru_pkg::*;
(
  input  bru_entry_t        ent,
  output logic              mispredict,
  output logic [BRU_AW-1:0] target,
  output logic [7:0]        setbyte
);
  logic cond_true;

  bru_cond_eval u_cond (
    .cc    (ent.cc),
    .flags (ent.flags),
    .holds (cond_true)
  );

  always_comb begin
    mispredict = 1'b0;
    target     = ent.fall_target;
    setbyte    = 8'h00;
    case (ent.op)
      OP_JCC, OP_UBR: begin
        target     = cond_true ? ent.taken_target : ent.fall_target;
        mispredict = cond_true != ent.pred_taken;
      end
      OP_SETCC: begin
        setbyte = {7'd0, cond_true};
      end
      OP_CALL, OP_RET: begin
        target     = ent.taken_target;
        mispredict = ent.pred_target != ent.taken_target;
      end
      default: begin
        mispredict = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bru_station.sv
module bru_station #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  output logic          push_ready,
  input  logic          pop,
  input  logic          flush,
  output logic          head_valid,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  slot   [DEPTH];
  logic [W-1:0]  slot_n [DEPTH];
  logic [CW-1:0] count_n;
  logic          empty, push_fire, bypass;

  assign empty      = count == '0;
  assign push_ready = count < CW'(DEPTH);
  assign push_fire  = push_valid && push_ready;
  assign head_valid = !empty || push_valid;
  assign head_data  = empty ? push_data : slot[0];
  assign bypass     = empty && pop;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_n[i] = slot[i];
    count_n = count;
    if (flush) begin
      count_n = '0;
    end else begin
      if (pop && !empty) begin
        for (int i = 0; i < DEPTH - 1; i++) slot_n[i] = slot[i+1];
        count_n = count - 1'b1;
      end
      if (push_fire && !bypass) begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == count_n) slot_n[i] = push_data;
        count_n = count_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) slot[g] <= slot_n[g];
    end
  endgenerate
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int unsigned RS_DEPTH = 2,
  localparam int unsigned CW      = $clog2(RS_DEPTH + 1),
  localparam int unsigned EW      = $bits(bru_entry_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [3:0]        in_cond,
  input  logic [BRU_FW-1:0] in_flags,
  input  logic              in_pred_taken,
  input  logic [BRU_AW-1:0] in_pred_target,
  input  logic [BRU_AW-1:0] in_fall_target,
  input  logic [BRU_AW-1:0] in_taken_target,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [2:0]        res_op,
  output logic              res_mispredict,
  output logic [BRU_AW-1:0] res_target,
  output logic [7:0]        res_setbyte
);
  bru_entry_t        in_ent, head_ent;
  logic [EW-1:0]     head_bits;
  logic              head_valid, issue_fire, issue_mispredict;
  logic [BRU_AW-1:0] issue_target;
  logic [7:0]        issue_byte;
  logic [CW-1:0]     rs_count;

  assign in_ent = '{op: in_op, cc: in_cond, flags: in_flags,
                    pred_taken: in_pred_taken, pred_target: in_pred_target,
                    fall_target: in_fall_target, taken_target: in_taken_target};

  bru_station #(.DEPTH(RS_DEPTH), .W(EW)) u_station (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (in_valid),
    .push_data  (in_ent),
    .push_ready (in_ready),
    .pop        (issue_fire),
    .flush      (issue_fire && issue_mispredict),
    .head_valid (head_valid),
    .head_data  (head_bits),
    .count      (rs_count)
  );

  assign head_ent   = bru_entry_t'(head_bits);
  assign issue_fire = head_valid && (!res_valid || res_ready);

  bru_resolve u_resolve (
    .ent        (head_ent),
    .mispredict (issue_mispredict),
    .target     (issue_target),
    .setbyte    (issue_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_op         <= 3'd0;
      res_mispredict <= 1'b0;
      res_target     <= '0;
      res_setbyte    <= 8'h00;
    end else if (issue_fire) begin
      res_valid      <= 1'b1;
      res_op         <= head_ent.op;
      res_mispredict <= issue_mispredict;
      res_target     <= issue_target;
      res_setbyte    <= issue_byte;
    end else if (res_ready) begin
      res_valid      <= 1'b0;
    end
  end
endmodule

// File: rtl/bru_checker.sv
module bru_checker
  import bru_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [2:0]        res_op,
  input logic              res_mispredict,
  input logic [BRU_AW-1:0] res_target,
  input logic [7:0]        res_setbyte,
  input logic [CW-1:0]     rs_count,
  input logic              issue_fire,
  input logic              issue_mispredict
);
  assert_setbyte_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_op == OP_SETCC |-> !res_mispredict);

  assert_byte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_op != OP_SETCC |-> res_setbyte == 8'h00);

  assert_exchange_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_op == OP_FXCH || res_op == 3'd6 || res_op == 3'd7) |-> !res_mispredict);

  assert_next_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> res_valid);

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !issue_fire |=> rs_count != '0);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire && issue_mispredict |=> rs_count == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_op) && $stable(res_target)
      && $stable(res_mispredict) && $stable(res_setbyte));
endmodule

bind branch_resolve_unit bru_checker #(.DEPTH(RS_DEPTH)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .in_ready         (in_ready),
  .res_valid        (res_valid),
  .res_ready        (res_ready),
  .res_op           (res_op),
  .res_mispredict   (res_mispredict),
  .res_target       (res_target),
  .res_setbyte      (res_setbyte),
  .rs_count         (rs_count),
  .issue_fire       (issue_fire),
  .issue_mispredict (issue_mispredict)
);

// File: tb/branch_resolve_unit_test.sv
module branch_resolve_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [2:0]  in_op = '0;
  logic [3:0]  in_cond = '0;
  logic [4:0]  in_flags = '0;
  logic        in_pred_taken = 1'b0;
  logic [31:0] in_pred_target = '0, in_fall_target = '0, in_taken_target = '0;
  logic        res_valid, res_ready = 1'b1;
  logic [2:0]  res_op;
  logic        res_mispredict;
  logic [31:0] res_target;
  logic [7:0]  res_setbyte;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  branch_resolve_unit uut (.*);

  typedef struct {
    logic [2:0] op; logic [3:0] cc; logic [4:0] fl; logic pt;
    logic [31:0] ptg, ftg, ttg;
  } op_t;

  function automatic logic cond_holds(logic [3:0] cc, logic [4:0] f);
    logic b;
    case (cc[3:1])
      3'd0: b = f[4];
      3'd1: b = f[0];
      3'd2: b = f[2];
      3'd3: b = f[0] | f[2];
      3'd4: b = f[3];
      3'd5: b = f[1];
      3'd6: b = f[3] ^ f[4];
      default: b = f[2] | (f[3] ^ f[4]);
    endcase
    return b ^ cc[0];
  endfunction

  function automatic logic exp_mp(op_t o);
    if (o.op == 3'd0 || o.op == 3'd5) return cond_holds(o.cc, o.fl) != o.pt;
    if (o.op == 3'd2 || o.op == 3'd3) return o.ptg != o.ttg;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_tgt(op_t o);
    if (o.op == 3'd0 || o.op == 3'd5) return cond_holds(o.cc, o.fl) ? o.ttg : o.ftg;
    if (o.op == 3'd2 || o.op == 3'd3) return o.ttg;
    return o.ftg;
  endfunction

  function automatic logic [7:0] exp_byte(op_t o);
    return (o.op == 3'd1) ? {7'd0, cond_holds(o.cc, o.fl)} : 8'h00;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(op_t o);
    in_valid = 1'b1; in_op = o.op; in_cond = o.cc; in_flags = o.fl;
    in_pred_taken = o.pt; in_pred_target = o.ptg;
    in_fall_target = o.ftg; in_taken_target = o.ttg;
  endtask

  function automatic op_t rand_op();
    op_t o;
    o.op = 3'($urandom_range(0, 7)); o.cc = 4'($urandom); o.fl = 5'($urandom);
    o.pt = 1'($urandom); o.ftg = $urandom; o.ttg = $urandom;
    o.ptg = $urandom_range(0, 1) ? o.ttg : $urandom;
    return o;
  endfunction

  task automatic check_result(op_t o, string tag);
    check(res_valid === 1'b1, "R7", 64'(res_valid), 64'd1);
    check(res_op === o.op, tag, 64'(res_op), 64'(o.op));
    check(res_mispredict === exp_mp(o), tag, 64'(res_mispredict), 64'(exp_mp(o)));
    check(res_target === exp_tgt(o), tag, 64'(res_target), 64'(exp_tgt(o)));
    check(res_setbyte === exp_byte(o), tag, 64'(res_setbyte), 64'(exp_byte(o)));
  endtask

  // One operation through an empty unit, with an optional output stall.
  task automatic single(op_t o, string tag, int stall);
    @(negedge clk);
    drive(o);
    res_ready = (stall == 0);
    @(negedge clk);
    in_valid = 1'b0;
    check_result(o, tag);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check_result(o, "R10");
    end
    res_ready = 1'b1;
  endtask

  // X blocks the output; A waits in the station; B either fills it (full test)
  // or arrives in the cycle A resolves (same-cycle flush test).
  task automatic stacked(op_t x, op_t a, op_t b, bit b_late);
    @(negedge clk); drive(x); res_ready = 1'b0;
    @(negedge clk); drive(a);
    @(negedge clk);
    check(in_ready === 1'b1, "R8", 64'(in_ready), 64'd1);
    if (!b_late) begin
      drive(b);
      @(negedge clk);
      in_valid = 1'b0;
      check(in_ready === 1'b0, "R8", 64'(in_ready), 64'd0);
      check_result(x, "R10");
      res_ready = 1'b1;
    end else begin
      drive(b);
      res_ready = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_result(a, tag_of(a.op));
    @(negedge clk);
    if (exp_mp(a)) check(res_valid === 1'b0, "R9", 64'(res_valid), 64'd0);
    else           check_result(b, "R8");
    @(negedge clk);
    check(res_valid === 1'b0, "R9", 64'(res_valid), 64'd0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    op_t o, a, b;
    void'($urandom(32'd7141));
    repeat (3) @(negedge clk);
    check(res_valid === 1'b0, "R11", 64'(res_valid), 64'd0);
    check(in_ready === 1'b1, "R11", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // R1: every condition code against several flag patterns, through a jump
    // predicted not taken: mispredict equals the condition result.
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 4; p++) begin
        o = rand_op();
        o.op = 3'd0; o.cc = 4'(c); o.pt = 1'b0;
        o.fl = (p == 0) ? 5'h00 : (p == 1) ? 5'h1f : (p == 2) ? 5'h08 : 5'($urandom);
        single(o, "R1", 0);
      end
    end

    // Directed: call with matching target, return with wrong target.
    o = rand_op(); o.op = 3'd2; o.ptg = o.ttg; single(o, "R4", 0);
    o = rand_op(); o.op = 3'd3; o.ptg = ~o.ttg; single(o, "R4", 0);

    // Random mix with occasional output stalls.
    for (int i = 0; i < 300; i++) begin
      o = rand_op();
      single(o, tag_of(o.op), ($urandom_range(0, 3) == 0) ? 2 : 0);
    end

    // Full station, order and flush.
    o = rand_op(); o.op = 3'd4;
    a = rand_op(); a.op = 3'd0; a.cc = 4'h4; a.fl = 5'h04; a.pt = 1'b1;
    b = rand_op(); b.op = 3'd1;
    stacked(o, a, b, 1'b0);
    a.pt = 1'b0;
    stacked(o, a, b, 1'b0);
    stacked(o, a, b, 1'b1);
    a.op = 3'd3; a.ptg = a.ttg;
    stacked(o, a, b, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule